// File: doc/BRIEF.md
# Microcoded Field-Arithmetic Sequencer

This block steps through a statically scheduled program and drives, cycle by cycle, everything around a wide finite-field datapath. The datapath has a two-port operand register file, one adder/subtractor and several multipliers. A program counter addresses an external instruction store. Each fetched word tells the block what to do in that cycle:
- the address and read/write action for each register-file port,
- whether the adder starts, and in which mode,
- whether a multiplier starts, and which one,
- which unit's result is written back.

The block has no hazard detection. The program order alone keeps reads, results and write-backs in step. Operands reach the units two cycles after the instruction that reads them. A write-back happens at the end of the instruction cycle that names it.

A host loads operands and collects results through a 64-bit word port while the block is idle. Each wide register is reached as consecutive 64-bit words. A start pulse launches a program at a chosen entry address. A busy flag stays high until the program fetches its halt instruction. The arithmetic units sit outside the block. Their results come back on input ports.

Top module: `fa_seq_ctrl`

## Requirements
- R1: After reset, busy_o, add_issue_o, mul_start_o and host_rvalid_o are all low.
- R2: A start_i pulse while idle sets busy_o and makes pc_o equal to entry_i in the next cycle. While busy_o stays high, pc_o increases by one every cycle.
- R3: When the fetched instruction has its halt bit set (the most significant bit of the instruction word), busy_o is low from the next cycle. None of the other fields of that instruction has any effect.
- R4: A start_i pulse while busy_o is high is ignored.
- R5: An instruction that reads port A and port B presents the two registers on op_a_o and op_b_o exactly two cycles later. In that same cycle the block raises add_issue_o and add_sub_o (add_sub 1 = subtract), and/or the one-hot bit of mul_start_o for the unit index in the instruction.
- R6: A port write stores, at the end of the instruction cycle, either add_res_i (source bit 0) or the multiplier result picked by the result-select field (source bit 1).
- R7: Both ports can read, or both can write, in the same instruction.
- R8: A host write while idle stores host_wdata_i into word host_word_i of register host_reg_i, at bits [64*w+63:64*w]. The other words of that register are unchanged.
- R9: A host read while idle returns the selected word on host_rdata_o, with host_rvalid_o high, exactly two cycles after the request.
- R10: Host writes and reads issued while busy_o is high have no effect: nothing is stored and no host_rvalid_o pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch pulse for a program |
| entry_i | input | PC_W | Program entry address |
| busy_o | output | 1 | High while a program runs |
| pc_o | output | PC_W | Instruction store address |
| instr_i | input | 30 | Instruction word fetched at pc_o |
| op_a_o | output | REG_W | Operand read on port A |
| op_b_o | output | REG_W | Operand read on port B |
| add_issue_o | output | 1 | Adder start |
| add_sub_o | output | 1 | Adder mode: 1 subtract, 0 add |
| mul_start_o | output | N_MUL | One-hot multiplier start |
| add_res_i | input | REG_W | Adder result |
| mul_res_i | input | N_MUL*REG_W | Multiplier results, unit 0 in the low slice |
| host_we_i | input | 1 | Host word write |
| host_re_i | input | 1 | Host word read |
| host_reg_i | input | 8 | Host register index |
| host_word_i | input | WIDX_W | Host word index inside a register |
| host_wdata_i | input | WORD_W | Host write data |
| host_rdata_o | output | WORD_W | Host read data |
| host_rvalid_o | output | 1 | Host read data valid |

## Verification
The assertions assume that start_i and host accesses arrive only after reset is released. They also assume that the instruction store answers pc_o within the same cycle, so the halt bit they watch always belongs to the current fetch. The bench keeps to this by modelling the instruction store as a combinational table indexed by pc_o, and by driving every input on the falling edge. The programs it runs respect the schedule: results are written back only in the cycles when the stub units present them, and no two ports write the same register together.

// File: rtl/fa_ctrl_pkg.sv
package fa_ctrl_pkg;

    localparam int REG_ADDR_W = 8;
    localparam int MUL_IDX_W  = 2;
    localparam int RD_LAT     = 2;

    typedef enum logic [0:0] {
        SRC_ADD = 1'b0,
        SRC_MUL = 1'b1
    } wb_src_e;

    // halt must stay the most significant field
    typedef struct packed {
        logic                  halt;
        logic [REG_ADDR_W-1:0] a_addr;
        logic                  a_rd;
        logic                  a_wr;
        wb_src_e               a_src;
        logic [REG_ADDR_W-1:0] b_addr;
        logic                  b_rd;
        logic                  b_wr;
        wb_src_e               b_src;
        logic                  add_go;
        logic                  add_sub;
        logic                  mul_go;
        logic [MUL_IDX_W-1:0]  mul_unit;
        logic [MUL_IDX_W-1:0]  mul_rsel;
    } instr_t;

    localparam int INSTR_W = $bits(instr_t);

    typedef struct packed {
        logic                 add_go;
        logic                 add_sub;
        logic                 mul_go;
        logic [MUL_IDX_W-1:0] mul_unit;
    } issue_t;

endpackage

// File: rtl/fa_regfile.sv
module fa_regfile #(
    parameter int ADDR_W = 8,
    parameter int WORDS  = 2,
    parameter int WORD_W = 64,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int REG_W = WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [WORDS-1:0]  a_wmask,
    input  logic [REG_W-1:0]  a_wdata,
    output logic [REG_W-1:0]  a_rdata,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [WORDS-1:0]  b_wmask,
    input  logic [REG_W-1:0]  b_wdata,
    output logic [REG_W-1:0]  b_rdata
);

    logic [WORD_W-1:0] mem [DEPTH][WORDS];
    logic [REG_W-1:0]  a_s1_q, a_s2_q, b_s1_q, b_s2_q;

    // a port either writes or reads in a cycle; two read stages
    always_ff @(posedge clk) begin
        for (int w = 0; w < WORDS; w++) begin
            if (a_en && a_we && a_wmask[w])
                mem[a_addr][w] <= a_wdata[w*WORD_W +: WORD_W];
            if (b_en && b_we && b_wmask[w])
                mem[b_addr][w] <= b_wdata[w*WORD_W +: WORD_W];
            if (a_en && !a_we)
                a_s1_q[w*WORD_W +: WORD_W] <= mem[a_addr][w];
            if (b_en && !b_we)
                b_s1_q[w*WORD_W +: WORD_W] <= mem[b_addr][w];
        end
        a_s2_q <= a_s1_q;
        b_s2_q <= b_s1_q;
    end

    assign a_rdata = a_s2_q;
    assign b_rdata = b_s2_q;

endmodule

// File: rtl/fa_wb_mux.sv
module fa_wb_mux #(
    parameter int N_MUL = 2,
    parameter int W     = 128,
    parameter int IDX_W = 2
) (
    input  logic [W-1:0]       add_res,
    input  logic [N_MUL*W-1:0] mul_res,
    input  logic               src_mul,
    input  logic [IDX_W-1:0]   rsel,
    output logic [W-1:0]       wdata
);

    logic [W-1:0] unit_res [N_MUL];

    for (genvar g = 0; g < N_MUL; g++) begin : g_unpack
        assign unit_res[g] = mul_res[g*W +: W];
    end

    always_comb begin
        wdata = add_res;
        if (src_mul) begin
            wdata = '0;
            for (int i = 0; i < N_MUL; i++)
                if (rsel == IDX_W'(i)) wdata = unit_res[i];
        end
    end

endmodule

// File: rtl/fa_delay_line.sv
module fa_delay_line #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
        end else begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/fa_seq_ctrl.sv
module fa_seq_ctrl
    import fa_ctrl_pkg::*;
#(
    parameter int PC_W   = 8,
    parameter int WORD_W = 64,
    parameter int WORDS  = 2,
    parameter int N_MUL  = 2,
    localparam int REG_W  = WORDS * WORD_W,
    localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [PC_W-1:0]       entry_i,
    output logic                  busy_o,
    output logic [PC_W-1:0]       pc_o,
    input  logic [INSTR_W-1:0]    instr_i,
    output logic [REG_W-1:0]      op_a_o,
    output logic [REG_W-1:0]      op_b_o,
    output logic                  add_issue_o,
    output logic                  add_sub_o,
    output logic [N_MUL-1:0]      mul_start_o,
    input  logic [REG_W-1:0]      add_res_i,
    input  logic [N_MUL*REG_W-1:0] mul_res_i,
    input  logic                  host_we_i,
    input  logic                  host_re_i,
    input  logic [REG_ADDR_W-1:0] host_reg_i,
    input  logic [WIDX_W-1:0]     host_word_i,
    input  logic [WORD_W-1:0]     host_wdata_i,
    output logic [WORD_W-1:0]     host_rdata_o,
    output logic                  host_rvalid_o
);

    localparam int ISS_W = $bits(issue_t);
    localparam int TAG_W = 1 + WIDX_W;

    typedef struct packed {
        logic            busy;
        logic [PC_W-1:0] pc;
    } ctl_t;

    ctl_t   ctl_d, ctl_q;
    instr_t ins;
    logic   run_ok;

    assign ins    = instr_t'(instr_i);
    assign run_ok = ctl_q.busy && !ins.halt;

    // sequencing: launch, step, stop on halt
    always_comb begin
        ctl_d = ctl_q;
        if (ctl_q.busy) begin
            ctl_d.pc = ctl_q.pc + 1'b1;
            if (ins.halt) ctl_d.busy = 1'b0;
        end else if (start_i) begin
            ctl_d.busy = 1'b1;
            ctl_d.pc   = entry_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign busy_o = ctl_q.busy;
    assign pc_o   = ctl_q.pc;

    // write-back data per port
    logic [REG_W-1:0] wb_a, wb_b;

    fa_wb_mux #(.N_MUL(N_MUL), .W(REG_W), .IDX_W(MUL_IDX_W)) u_wb_a (
        .add_res (add_res_i),
        .mul_res (mul_res_i),
        .src_mul (ins.a_src == SRC_MUL),
        .rsel    (ins.mul_rsel),
        .wdata   (wb_a)
    );

    fa_wb_mux #(.N_MUL(N_MUL), .W(REG_W), .IDX_W(MUL_IDX_W)) u_wb_b (
        .add_res (add_res_i),
        .mul_res (mul_res_i),
        .src_mul (ins.b_src == SRC_MUL),
        .rsel    (ins.mul_rsel),
        .wdata   (wb_b)
    );

    // register file port control: host owns port A while idle
    logic                  pa_en, pa_we, pb_en, pb_we;
    logic [REG_ADDR_W-1:0] pa_addr, pb_addr;
    logic [WORDS-1:0]      pa_mask, host_mask;
    logic [REG_W-1:0]      pa_wdata, pa_rdata, pb_rdata;
    logic                  host_rd_go;

    assign host_rd_go = host_re_i && !host_we_i && !ctl_q.busy;

    always_comb begin
        for (int w = 0; w < WORDS; w++)
            host_mask[w] = (host_word_i == WIDX_W'(w));
    end

    always_comb begin
        if (!ctl_q.busy) begin
            pa_en    = host_we_i || host_re_i;
            pa_we    = host_we_i;
            pa_addr  = host_reg_i;
            pa_mask  = host_mask;
            pa_wdata = {WORDS{host_wdata_i}};
        end else begin
            pa_en    = run_ok && (ins.a_rd || ins.a_wr);
            pa_we    = ins.a_wr;
            pa_addr  = ins.a_addr;
            pa_mask  = '1;
            pa_wdata = wb_a;
        end
        pb_en   = run_ok && (ins.b_rd || ins.b_wr);
        pb_we   = ins.b_wr;
        pb_addr = ins.b_addr;
    end

    fa_regfile #(.ADDR_W(REG_ADDR_W), .WORDS(WORDS), .WORD_W(WORD_W)) u_rf (
        .clk     (clk),
        .a_en    (pa_en),
        .a_we    (pa_we),
        .a_addr  (pa_addr),
        .a_wmask (pa_mask),
        .a_wdata (pa_wdata),
        .a_rdata (pa_rdata),
        .b_en    (pb_en),
        .b_we    (pb_we),
        .b_addr  (pb_addr),
        .b_wmask ('1),
        .b_wdata (wb_b),
        .b_rdata (pb_rdata)
    );

    assign op_a_o = pa_rdata;
    assign op_b_o = pb_rdata;

    // unit issue delayed to meet the operands
    issue_t iss_in, iss_q;
    logic [ISS_W-1:0] iss_raw;

    always_comb begin
        iss_in.add_go   = run_ok && ins.add_go;
        iss_in.add_sub  = ins.add_sub;
        iss_in.mul_go   = run_ok && ins.mul_go;
        iss_in.mul_unit = ins.mul_unit;
    end

    fa_delay_line #(.W(ISS_W), .STAGES(RD_LAT)) u_iss_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (iss_in),
        .dout  (iss_raw)
    );

    assign iss_q       = issue_t'(iss_raw);
    assign add_issue_o = iss_q.add_go;
    assign add_sub_o   = iss_q.add_go && iss_q.add_sub;

    for (genvar g = 0; g < N_MUL; g++) begin : g_mstart
        assign mul_start_o[g] = iss_q.mul_go && (iss_q.mul_unit == MUL_IDX_W'(g));
    end

    // host read tag follows the read pipeline
    logic [TAG_W-1:0] tag_out;
    logic [WIDX_W-1:0] tag_word;

    fa_delay_line #(.W(TAG_W), .STAGES(RD_LAT)) u_tag_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({host_rd_go, host_word_i}),
        .dout  (tag_out)
    );

    assign host_rvalid_o = tag_out[TAG_W-1];
    assign tag_word      = tag_out[WIDX_W-1:0];

    always_comb begin
        host_rdata_o = '0;
        for (int w = 0; w < WORDS; w++)
            if (tag_word == WIDX_W'(w)) host_rdata_o = pa_rdata[w*WORD_W +: WORD_W];
    end

endmodule

// File: rtl/fa_seq_ctrl_chk.sv
module fa_seq_ctrl_chk #(
    parameter int PC_W  = 8,
    parameter int N_MUL = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [PC_W-1:0]  entry_i,
    input logic             busy_o,
    input logic [PC_W-1:0]  pc_o,
    input logic             halt_i,
    input logic             add_issue_o,
    input logic [N_MUL-1:0] mul_start_o,
    input logic             host_we_i,
    input logic             host_re_i,
    input logic             host_rvalid_o
);

    a_r2_start_load: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && pc_o == $past(entry_i)));

    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> (pc_o == $past(pc_o) + 1'b1));

    a_r3_halt_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && halt_i) |=> !busy_o);

    a_r4_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !halt_i && start_i) |=> (busy_o && pc_o == $past(pc_o) + 1'b1));

    a_r5_mul_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mul_start_o));

    a_r5_issue_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        (add_issue_o || (|mul_start_o)) |-> $past(busy_o, 2));

    a_r9_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (host_re_i && !host_we_i && !busy_o) |=> ##1 host_rvalid_o);

    a_r10_read_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (host_re_i && busy_o) |=> ##1 !host_rvalid_o);

endmodule

bind fa_seq_ctrl fa_seq_ctrl_chk #(.PC_W(PC_W), .N_MUL(N_MUL)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .entry_i       (entry_i),
    .busy_o        (busy_o),
    .pc_o          (pc_o),
    .halt_i        (instr_i[fa_ctrl_pkg::INSTR_W-1]),
    .add_issue_o   (add_issue_o),
    .mul_start_o   (mul_start_o),
    .host_we_i     (host_we_i),
    .host_re_i     (host_re_i),
    .host_rvalid_o (host_rvalid_o)
);

// File: tb/tb_fa_seq_ctrl.sv
module tb_fa_seq_ctrl;
    import fa_ctrl_pkg::*;

    localparam int PC_W = 8, WORD_W = 64, WORDS = 2, N_MUL = 2;
    localparam int REG_W = WORDS * WORD_W;

    logic clk = 1'b0, rst_n = 1'b0;
    always #10 clk = ~clk;

    logic                   start_i = 0;
    logic [PC_W-1:0]        entry_i = '0;
    logic                   busy_o, add_issue_o, add_sub_o, host_rvalid_o;
    logic [PC_W-1:0]        pc_o;
    logic [INSTR_W-1:0]     instr_i;
    logic [REG_W-1:0]       op_a_o, op_b_o, add_res;
    logic [REG_W-1:0]       mul_res [N_MUL];
    logic [N_MUL*REG_W-1:0] mul_flat;
    logic [N_MUL-1:0]       mul_start_o;
    logic                   host_we_i = 0, host_re_i = 0;
    logic [7:0]             host_reg_i = '0;
    logic                   host_word_i = 0;
    logic [WORD_W-1:0]      host_wdata_i = '0, host_rdata_o;

    instr_t rom [256];
    assign instr_i = rom[pc_o];
    assign mul_flat = {mul_res[1], mul_res[0]};

    fa_seq_ctrl #(.PC_W(PC_W), .WORD_W(WORD_W), .WORDS(WORDS), .N_MUL(N_MUL)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .entry_i(entry_i),
        .busy_o(busy_o), .pc_o(pc_o), .instr_i(instr_i),
        .op_a_o(op_a_o), .op_b_o(op_b_o), .add_issue_o(add_issue_o),
        .add_sub_o(add_sub_o), .mul_start_o(mul_start_o),
        .add_res_i(add_res), .mul_res_i(mul_flat),
        .host_we_i(host_we_i), .host_re_i(host_re_i), .host_reg_i(host_reg_i),
        .host_word_i(host_word_i), .host_wdata_i(host_wdata_i),
        .host_rdata_o(host_rdata_o), .host_rvalid_o(host_rvalid_o)
    );

    // stub units: result register loaded at the issue edge
    always @(posedge clk) begin
        if (add_issue_o) add_res <= add_sub_o ? op_a_o - op_b_o : op_a_o + op_b_o;
        for (int i = 0; i < N_MUL; i++)
            if (mul_start_o[i]) mul_res[i] <= op_a_o * op_b_o;
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [REG_W-1:0] act, input logic [REG_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // scoreboard items
    typedef struct {
        int              cyc;
        logic            add;
        logic            sub;
        logic [N_MUL-1:0] ms;
        logic [REG_W-1:0] a;
        logic [REG_W-1:0] b;
    } iss_item_t;
    typedef struct {
        int                cyc;
        logic [WORD_W-1:0] data;
        string             req;
    } rd_item_t;

    iss_item_t iss_q[$];
    rd_item_t  rd_q[$];

    always @(negedge clk) begin
        if (rst_n && (add_issue_o || (|mul_start_o))) begin
            if (iss_q.size() == 0) begin
                check(0, "R5", "unexpected issue", REG_W'(cyc), '0);
            end else begin
                iss_item_t e;
                e = iss_q.pop_front();
                check(cyc == e.cyc, "R5", "issue cycle", REG_W'(cyc), REG_W'(e.cyc));
                check(add_issue_o == e.add && add_sub_o == e.sub && mul_start_o == e.ms,
                      "R5", "issue controls", {add_issue_o, add_sub_o, mul_start_o},
                      {e.add, e.sub, e.ms});
                check(op_a_o == e.a, "R5", "operand A", op_a_o, e.a);
                check(op_b_o == e.b, "R5", "operand B", op_b_o, e.b);
            end
        end
        if (rst_n && host_rvalid_o) begin
            if (rd_q.size() == 0) begin
                check(0, "R10", "unexpected host read data", REG_W'(cyc), '0);
            end else begin
                rd_item_t r;
                r = rd_q.pop_front();
                check(cyc == r.cyc, "R9", "read cycle", REG_W'(cyc), REG_W'(r.cyc));
                check(host_rdata_o == r.data, r.req, "read data",
                      REG_W'(host_rdata_o), REG_W'(r.data));
            end
        end
    end

    task automatic host_wr(input logic [7:0] r, input logic w, input logic [63:0] d);
        host_we_i = 1; host_reg_i = r; host_word_i = w; host_wdata_i = d;
        @(negedge clk);
        host_we_i = 0;
    endtask

    task automatic host_rd(input logic [7:0] r, input logic w, input logic [63:0] exp,
                           input string req);
        rd_item_t it;
        it.cyc = cyc + 2; it.data = exp; it.req = req;
        rd_q.push_back(it);
        host_re_i = 1; host_reg_i = r; host_word_i = w;
        @(negedge clk);
        host_re_i = 0;
    endtask

    task automatic push_iss(input int c, input logic ad, input logic sb,
                            input logic [N_MUL-1:0] ms,
                            input logic [REG_W-1:0] a, input logic [REG_W-1:0] b);
        iss_item_t e;
        e.cyc = c; e.add = ad; e.sub = sb; e.ms = ms; e.a = a; e.b = b;
        iss_q.push_back(e);
    endtask

    localparam logic [REG_W-1:0] X = {64'h0123_4567_89ab_cdef, 64'hfedc_ba98_7654_3210};
    localparam logic [REG_W-1:0] Y = {64'h0000_0000_0000_0001, 64'hffff_ffff_ffff_fff0};
    localparam logic [REG_W-1:0] Z = {64'h0, 64'h3};
    localparam logic [REG_W-1:0] K30 = {64'h3030_3030_3030_3030, 64'h0303_0303_0303_0303};

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [REG_W-1:0] s, d;
        int st;
        s = X + Y; d = X - Y;

        for (int i = 0; i < 256; i++) begin
            rom[i] = '0;
            rom[i].halt = 1'b1;
        end
        rom[4] = '0; rom[4].a_rd = 1; rom[4].a_addr = 10; rom[4].b_rd = 1; rom[4].b_addr = 11;
        rom[4].add_go = 1;
        rom[5] = rom[4]; rom[5].add_sub = 1;
        rom[6] = '0;
        rom[7] = '0; rom[7].a_wr = 1; rom[7].a_addr = 13; rom[7].a_src = SRC_ADD;
        rom[8] = '0; rom[8].b_wr = 1; rom[8].b_addr = 21; rom[8].b_src = SRC_ADD;
        rom[9] = '0; rom[9].a_rd = 1; rom[9].a_addr = 13; rom[9].b_rd = 1; rom[9].b_addr = 12;
        rom[9].mul_go = 1; rom[9].mul_unit = 1;
        rom[10] = '0; rom[10].a_rd = 1; rom[10].a_addr = 13; rom[10].b_rd = 1;
        rom[10].b_addr = 11; rom[10].mul_go = 1; rom[10].mul_unit = 0;
        rom[11] = '0;
        rom[12] = '0; rom[12].a_wr = 1; rom[12].a_addr = 20; rom[12].a_src = SRC_MUL;
        rom[12].mul_rsel = 1; rom[12].b_wr = 1; rom[12].b_addr = 23; rom[12].b_src = SRC_ADD;
        rom[13] = '0; rom[13].b_wr = 1; rom[13].b_addr = 22; rom[13].b_src = SRC_MUL;
        rom[13].mul_rsel = 0;
        rom[14] = '0; rom[14].halt = 1; rom[14].a_wr = 1; rom[14].a_addr = 30;
        rom[14].a_src = SRC_ADD; rom[14].add_go = 1;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy_o && !add_issue_o && mul_start_o == '0 && !host_rvalid_o, "R1",
              "reset outputs", {busy_o, add_issue_o, mul_start_o, host_rvalid_o}, '0);
        rst_n = 1;
        @(negedge clk);

        // R8 host loading
        host_wr(10, 0, X[63:0]);  host_wr(10, 1, X[127:64]);
        host_wr(11, 0, Y[63:0]);  host_wr(11, 1, Y[127:64]);
        host_wr(12, 0, Z[63:0]);  host_wr(12, 1, Z[127:64]);
        host_wr(30, 0, K30[63:0]); host_wr(30, 1, K30[127:64]);
        host_wr(40, 0, 64'haaaa_0000_bbbb_1111); host_wr(40, 1, 64'hcccc_2222_dddd_3333);
        host_wr(40, 1, 64'h4444_5555_6666_7777);
        // R9 read timing and R8 word placement and isolation
        host_rd(10, 1, X[127:64], "R8");
        host_rd(10, 0, X[63:0], "R9");
        host_rd(40, 0, 64'haaaa_0000_bbbb_1111, "R8");
        host_rd(40, 1, 64'h4444_5555_6666_7777, "R8");
        repeat (3) @(negedge clk);

        // program run
        start_i = 1; entry_i = 8'd4;
        @(negedge clk);
        start_i = 0;
        st = cyc;
        push_iss(st + 2, 1, 0, 2'b00, X, Y);
        push_iss(st + 3, 1, 1, 2'b00, X, Y);
        push_iss(st + 7, 0, 0, 2'b10, s, Z);
        push_iss(st + 8, 0, 0, 2'b01, s, Y);
        for (int k = 0; k < 14; k++) begin
            if (k == 0) check(busy_o && pc_o == 8'd4, "R2", "entry load",
                              REG_W'({busy_o, pc_o}), REG_W'({1'b1, 8'd4}));
            if (k == 6) check(pc_o == 8'd10, "R2", "pc step", REG_W'(pc_o), REG_W'(8'd10));
            if (k == 7) check(!host_rvalid_o, "R10", "read while busy", REG_W'(host_rvalid_o), '0);
            if (k == 10) check(busy_o, "R4", "busy through halt fetch", REG_W'(busy_o), 1);
            if (k == 11) check(!busy_o, "R3", "busy drop after halt", REG_W'(busy_o), 0);
            host_we_i = (k == 3); host_wdata_i = 64'hdead_beef_dead_beef;
            host_reg_i = (k == 3) ? 8'd40 : 8'd10; host_word_i = 0;
            host_re_i = (k == 5);
            start_i = (k == 6); entry_i = 8'd0;
            @(negedge clk);
        end
        host_we_i = 0; host_re_i = 0; start_i = 0;

        // results
        host_rd(13, 0, s[63:0], "R6"); host_rd(13, 1, s[127:64], "R6");
        host_rd(21, 0, d[63:0], "R6"); host_rd(21, 1, d[127:64], "R6");
        host_rd(20, 0, REG_W'(s * Z) & 128'hffff_ffff_ffff_ffff, "R6");
        host_rd(20, 1, 64'((s * Z) >> 64), "R6");
        host_rd(22, 0, 64'(s * Y), "R7"); host_rd(22, 1, 64'((s * Y) >> 64), "R7");
        host_rd(23, 0, d[63:0], "R7"); host_rd(23, 1, d[127:64], "R7");
        host_rd(30, 0, K30[63:0], "R3"); host_rd(30, 1, K30[127:64], "R3");
        host_rd(40, 0, 64'haaaa_0000_bbbb_1111, "R10");
        repeat (4) @(negedge clk);
        check(iss_q.size() == 0, "R5", "missing issues", REG_W'(iss_q.size()), 0);
        check(rd_q.size() == 0, "R9", "missing reads", REG_W'(rd_q.size()), 0);
        check(!busy_o, "R4", "stays idle", REG_W'(busy_o), 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule